// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This controller holds the power state of a device that can sit in one of five modes: full-speed Run, Wait (core halted), Stop (system clocks halted), Standby (slow-clock operation) and Power-Down (everything off). From that state it drives two registered clock-enable outputs: one for the core and memory clock and one for the system and peripheral clock. It also drives the power controls for the clock source, the PLL, the oscillator and the main regulator.

Software moves the device out of Run in two ways. It can issue a one-cycle halt strobe (wait or stop). It can also write a configuration request that walks the analog controls into Standby one step per cycle, and from there into Power-Down. Each low-power mode accepts only its own wake events. Stop wake-ups from peripherals are filtered by a per-peripheral enable mask. Leaving Standby walks the controls back in reverse order and holds the slow-clock selection until the PLL reports lock.

The enable and control outputs feed clock gates and analog cells elsewhere on the chip. All of them are flops, so their changes line up with clock edges.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` is held low at a clock edge, `mode` is 0 (Run), both clock enables are 1, all five power controls are 0 and `stop_en` is all zeros.
- R2: In Run, with no Standby sequence in progress, `wait_stb` without `stop_stb` moves the block to Wait (`mode`=1) at the next edge. In Wait, `core_clk_en` is 0 and `periph_clk_en` is 1.
- R3: In Wait, any of `irq_any`, `lvi_irq`, `dbg_enter` or any `periph_irq` bit returns the block to Run (`mode`=0) at the next edge, with both enables 1.
- R4: In Run, with no Standby sequence in progress, `stop_stb` moves the block to Stop (`mode`=2) with both enables 0. This holds even when `wait_stb` is high in the same cycle.
- R5: In Stop, only three events wake the block to Run at the next edge: a `periph_irq` bit whose `stop_en` bit is 1, `lvi_irq`, or `dbg_enter`. `irq_any` and masked peripheral interrupts leave it in Stop.
- R6: `stop_en` (one bit per peripheral, bit i for `periph_irq[i]`) loads `stop_en_wdata` on `stop_en_wr` only in Run or Standby. Writes in other modes are ignored.
- R7: In Run, `stby_req` without a halt strobe starts the entry walk. On successive edges it raises `sel_slow_clk`, then `pll_pdn`, then `osc_stby`, then `vreg_stby`. `mode` becomes 3 one edge after `vreg_stby` rises. Both enables stay 1 throughout, and halt strobes are ignored while the walk is under way.
- R8: In Standby, `stby_exit` drops `vreg_stby`, `osc_stby` and `pll_pdn`, one per edge. `sel_slow_clk` stays 1 until an edge with `pll_lock` high clears it. `mode` returns to 0 one edge after that.
- R9: In a completed Standby, `pdn_req` moves the block to Power-Down (`mode`=4) at the next edge, with `osc_pdn` 1, both enables 0 and the Standby controls still 1.
- R10: In Power-Down, `irq_any`, `periph_irq`, `lvi_irq`, `dbg_enter`, `sw_rst` and `wdog_rst` have no effect, and `stop_en` is kept. `ext_rst` returns the block to Run with all controls 0.
- R11: Outside Power-Down, `ext_rst`, `sw_rst` or `wdog_rst` puts the block in Run at the next edge, with both enables 1, all controls 0 and `stop_en` cleared. This overrides a halt strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst | input | 1 | External reset request |
| sw_rst | input | 1 | Software reset request |
| wdog_rst | input | 1 | Watchdog reset request |
| wait_stb | input | 1 | Wait-halt strobe from the core |
| stop_stb | input | 1 | Stop-halt strobe from the core |
| irq_any | input | 1 | Any pending interrupt at the core |
| periph_irq | input | NP | Per-peripheral interrupt lines |
| lvi_irq | input | 1 | Low-voltage interrupt |
| dbg_enter | input | 1 | Debug-entry command |
| stop_en_wr | input | 1 | Write strobe for the stop-wake mask |
| stop_en_wdata | input | NP | New stop-wake mask |
| stby_req | input | 1 | Configuration request to enter Standby |
| stby_exit | input | 1 | Configuration request to leave Standby |
| pdn_req | input | 1 | Configuration request to power down the oscillator |
| pll_lock | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Core and memory clock enable |
| periph_clk_en | output | 1 | System and peripheral clock enable |
| sel_slow_clk | output | 1 | Select the slow internal oscillator |
| pll_pdn | output | 1 | PLL power-down |
| osc_stby | output | 1 | Oscillator standby |
| vreg_stby | output | 1 | Main regulator standby |
| osc_pdn | output | 1 | Oscillator power-down |
| stop_en | output | NP | Stop-wake mask per peripheral |
| mode | output | 3 | Current mode: 0 Run, 1 Wait, 2 Stop, 3 Standby, 4 Power-Down |

## Verification
Two pairs of events can land on the same edge and must be resolved by priority.

The first pair is a reset request and a halt strobe. One table row drives `stop_stb` together with `wdog_rst`. The check expects Run with both enables high on the following cycle, not Stop.

The second pair is the two halt strobes together. That row must land in Stop with both enables low.

A further directed case raises `wait_stb` in the middle of the Standby entry walk. It is judged by the control outputs continuing their one-step-per-edge climb while `mode` stays at Run.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power mode controller.
// Assumes the mode codes below are decoded by status readers.
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_RUN  = 3'd0,
        PM_WAIT = 3'd1,
        PM_STOP = 3'd2,
        PM_STBY = 3'd3,
        PM_PDN  = 3'd4
    } pm_mode_e;

    // Standby walk: number of steps and the position of each control in the walk.
    localparam int unsigned PM_NSTEP = 4;
    localparam int unsigned SI_SLOW  = 0;
    localparam int unsigned SI_PLL   = 1;
    localparam int unsigned SI_OSC   = 2;
    localparam int unsigned SI_VREG  = 3;

endpackage

// File: rtl/pwr_wake_qual.sv
// Wake and reset qualification.
// Purely combinational. It decides, for the current mode, whether a reset
// request applies and whether an event is a legal wake source.
// Assumes all inputs are synchronous to the controller clock.
module pwr_wake_qual
    import pwr_mode_pkg::*;
#(
    parameter int unsigned NP = 4
) (
    input  pm_mode_e          mode_q,
    input  logic              irq_any,
    input  logic [NP-1:0]     periph_irq,
    input  logic [NP-1:0]     stop_en,
    input  logic              lvi_irq,
    input  logic              dbg_enter,
    input  logic              ext_rst,
    input  logic              sw_rst,
    input  logic              wdog_rst,
    output logic              rst_hit,
    output logic              wake
);

    // Reset qualification: only the external reset reaches a powered-down device.
    always_comb begin
        rst_hit = ext_rst | ((sw_rst | wdog_rst) & (mode_q != PM_PDN));
    end

    // Per-mode wake source selection.
    always_comb begin
        unique case (mode_q)
            PM_WAIT: wake = irq_any | lvi_irq | dbg_enter | (|periph_irq);
            PM_STOP: wake = (|(periph_irq & stop_en)) | lvi_irq | dbg_enter;
            default: wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_stby_seq.sv
// Standby control walk.
// A thermometer shift register. Bit k is the k-th control raised on the way
// into Standby. Stepping up sets one more bit per edge. Stepping down clears
// the top bit per edge. The last bit (clock-source select) clears only when
// the PLL reports lock.
// Assumes NSTEP >= 2 and that step_up and step_dn are never needed together.
module pwr_stby_seq #(
    parameter int unsigned NSTEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             pll_lock,
    output logic [NSTEP-1:0] ctl,
    output logic             full,
    output logic             empty
);

    localparam logic [NSTEP-1:0] ALL_ON = '1;
    localparam logic [NSTEP-1:0] LAST   = NSTEP'(1);

    // Walk register: one control per edge, reversed on the way out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ctl <= '0;
        end else if (step_up && (ctl != ALL_ON)) begin
            ctl <= {ctl[NSTEP-2:0], 1'b1};
        end else if (step_dn && (ctl != '0) && ((ctl != LAST) || pll_lock)) begin
            ctl <= ctl >> 1;
        end
    end

    // End-of-walk flags.
    always_comb begin
        full  = (ctl == ALL_ON);
        empty = (ctl == '0);
    end

    // R7: controls always form a thermometer code.
    p_thermo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl + LAST) & ctl) == '0);

    // R7: no more than one control changes per edge unless cleared.
    p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones(ctl) <= $countones($past(ctl)) + 1) &&
                 ($countones($past(ctl)) <= $countones(ctl) + 1));

    // R8: clock source stays slow until the PLL locks.
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == LAST && !pll_lock && !clr && !step_up) |=> ctl == LAST);

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode controller top.
// Holds the device mode, the stop-wake mask and the oscillator power-down
// flop. It drives registered clock enables that change only at clock edges.
// Assumes all inputs are synchronous to clk and that halt strobes last one
// cycle.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_rst,
    input  logic          sw_rst,
    input  logic          wdog_rst,
    input  logic          wait_stb,
    input  logic          stop_stb,
    input  logic          irq_any,
    input  logic [NP-1:0] periph_irq,
    input  logic          lvi_irq,
    input  logic          dbg_enter,
    input  logic          stop_en_wr,
    input  logic [NP-1:0] stop_en_wdata,
    input  logic          stby_req,
    input  logic          stby_exit,
    input  logic          pdn_req,
    input  logic          pll_lock,
    output logic          core_clk_en,
    output logic          periph_clk_en,
    output logic          sel_slow_clk,
    output logic          pll_pdn,
    output logic          osc_stby,
    output logic          vreg_stby,
    output logic          osc_pdn,
    output logic [NP-1:0] stop_en,
    output logic [2:0]    mode
);

    pm_mode_e              mode_q, mode_d;
    logic                  rst_hit, wake;
    logic                  step_up, step_dn, go_pdn;
    logic [PM_NSTEP-1:0]   ctl;
    logic                  seq_full, seq_empty;
    logic                  core_en_q, per_en_q, osc_pd_q;
    logic [NP-1:0]         stop_en_q;
    logic                  mask_wr_ok;

    pwr_wake_qual #(.NP(NP)) u_wake (
        .mode_q     (mode_q),
        .irq_any    (irq_any),
        .periph_irq (periph_irq),
        .stop_en    (stop_en_q),
        .lvi_irq    (lvi_irq),
        .dbg_enter  (dbg_enter),
        .ext_rst    (ext_rst),
        .sw_rst     (sw_rst),
        .wdog_rst   (wdog_rst),
        .rst_hit    (rst_hit),
        .wake       (wake)
    );

    pwr_stby_seq #(.NSTEP(PM_NSTEP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rst_hit),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .pll_lock (pll_lock),
        .ctl      (ctl),
        .full     (seq_full),
        .empty    (seq_empty)
    );

    // Standby walk direction and power-down request qualification.
    always_comb begin
        step_up = (mode_q == PM_RUN) &&
                  (!seq_empty || (stby_req && !stop_stb && !wait_stb));
        step_dn = (mode_q == PM_STBY) && (!seq_full || stby_exit);
        go_pdn  = (mode_q == PM_STBY) && seq_full && pdn_req && !stby_exit;
    end

    // Next-mode selection; reset requests win over everything.
    always_comb begin
        mode_d = mode_q;
        if (rst_hit) begin
            mode_d = PM_RUN;
        end else begin
            unique case (mode_q)
                PM_RUN: begin
                    if (seq_empty && stop_stb)      mode_d = PM_STOP;
                    else if (seq_empty && wait_stb) mode_d = PM_WAIT;
                    else if (seq_full)              mode_d = PM_STBY;
                end
                PM_WAIT, PM_STOP: begin
                    if (wake) mode_d = PM_RUN;
                end
                PM_STBY: begin
                    if (go_pdn)         mode_d = PM_PDN;
                    else if (seq_empty) mode_d = PM_RUN;
                end
                PM_PDN:  mode_d = PM_PDN;
                default: mode_d = PM_RUN;
            endcase
        end
    end

    // Mode and clock-enable registers, loaded from the next mode so enables align with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= PM_RUN;
            core_en_q <= 1'b1;
            per_en_q  <= 1'b1;
            osc_pd_q  <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            core_en_q <= (mode_d == PM_RUN) || (mode_d == PM_STBY);
            per_en_q  <= (mode_d == PM_RUN) || (mode_d == PM_WAIT) || (mode_d == PM_STBY);
            osc_pd_q  <= (mode_d == PM_PDN);
        end
    end

    // Mask writes are accepted only while the core is executing.
    always_comb begin
        mask_wr_ok = stop_en_wr && ((mode_q == PM_RUN) || (mode_q == PM_STBY));
    end

    // One stop-wake mask flop per peripheral.
    for (genvar gi = 0; gi < NP; gi++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n || rst_hit) begin
                stop_en_q[gi] <= 1'b0;
            end else if (mask_wr_ok) begin
                stop_en_q[gi] <= stop_en_wdata[gi];
            end
        end
    end

    // Output mapping.
    always_comb begin
        core_clk_en   = core_en_q;
        periph_clk_en = per_en_q;
        sel_slow_clk  = ctl[SI_SLOW];
        pll_pdn       = ctl[SI_PLL];
        osc_stby      = ctl[SI_OSC];
        vreg_stby     = ctl[SI_VREG];
        osc_pdn       = osc_pd_q;
        stop_en       = stop_en_q;
        mode          = mode_q;
    end

    // R2: a lone wait strobe in idle Run halts only the core clock.
    p_wait_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_RUN && seq_empty && wait_stb && !stop_stb && !rst_hit)
        |=> (mode_q == PM_WAIT && !core_clk_en && periph_clk_en));

    // R3: any interrupt or debug entry ends Wait.
    p_wait_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_WAIT && (irq_any || dbg_enter || lvi_irq))
        |=> (mode_q == PM_RUN && core_clk_en && periph_clk_en));

    // R4: stop strobe in idle Run halts both clocks.
    p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_RUN && seq_empty && stop_stb && !rst_hit)
        |=> (mode_q == PM_STOP && !core_clk_en && !periph_clk_en));

    // R5: without a qualified source Stop persists.
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_STOP && !rst_hit && ((periph_irq & stop_en_q) == '0) &&
         !lvi_irq && !dbg_enter) |=> mode_q == PM_STOP);

    // R6: the mask cannot change while halted.
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == PM_WAIT || mode_q == PM_STOP || mode_q == PM_PDN) && !rst_hit)
        |=> $stable(stop_en_q));

    // R7: Standby keeps both clocks running.
    p_stby_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_STBY) |-> (core_clk_en && periph_clk_en));

    // R9: Power-Down has every clock off and the oscillator powered down.
    p_pdn_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_PDN) |-> (!core_clk_en && !periph_clk_en && osc_pdn && seq_full));

    // R10: only the external reset leaves Power-Down.
    p_pdn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_PDN && !ext_rst) |=> mode_q == PM_PDN);

    // R11: a reset request restores Run with all controls released.
    p_rst_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> (mode_q == PM_RUN && core_clk_en && periph_clk_en &&
                     ctl == '0 && !osc_pdn && stop_en_q == '0));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NV = 22;

    // Row: req[20:17] wt[16] st[15] irq[14] pirq[13:10] lvi[9] dbg[8]
    //      ext[7] sw[6] wd[5] mode[4:2] core[1] per[0]
    // Runs with stop_en = 4'b0101 until the sw reset row clears it.
    localparam logic [20:0] VEC [NV] = '{
        21'b0010_1_0_0_0000_0_0_0_0_0_001_0_1, // R2 wait entry
        21'b0011_0_0_0_0000_0_0_0_0_0_001_0_1, // R3 no event: stays
        21'b0011_0_0_1_0000_0_0_0_0_0_000_1_1, // R3 irq_any wakes
        21'b0010_1_0_0_0000_0_0_0_0_0_001_0_1, // R2
        21'b0011_0_0_0_0000_0_1_0_0_0_000_1_1, // R3 debug wakes
        21'b0010_1_0_0_0000_0_0_0_0_0_001_0_1, // R2
        21'b0011_0_0_0_0000_1_0_0_0_0_000_1_1, // R3 lvi wakes
        21'b0010_1_0_0_0000_0_0_0_0_0_001_0_1, // R2
        21'b0011_0_0_0_1000_0_0_0_0_0_000_1_1, // R3 peripheral wakes
        21'b0100_1_1_0_0000_0_0_0_0_0_010_0_0, // R4 both strobes: stop wins
        21'b0101_0_0_1_0000_0_0_0_0_0_010_0_0, // R5 irq_any ignored
        21'b0101_0_0_0_1010_0_0_0_0_0_010_0_0, // R5 masked peripherals ignored
        21'b0101_0_0_0_0100_0_0_0_0_0_000_1_1, // R5 enabled peripheral wakes
        21'b0100_0_1_0_0000_0_0_0_0_0_010_0_0, // R4
        21'b0101_0_0_0_0000_1_0_0_0_0_000_1_1, // R5 lvi wakes
        21'b0100_0_1_0_0000_0_0_0_0_0_010_0_0, // R4
        21'b0101_0_0_0_0000_0_1_0_0_0_000_1_1, // R5 debug wakes
        21'b0100_0_1_0_0000_0_0_0_0_0_010_0_0, // R4
        21'b1011_0_0_0_0000_0_0_0_1_0_000_1_1, // R11 sw reset leaves Stop
        21'b1011_0_1_0_0000_0_0_0_0_1_000_1_1, // R11 wdog beats stop strobe
        21'b0010_1_0_0_0000_0_0_0_0_0_001_0_1, // R2
        21'b1011_0_0_0_0000_0_0_1_0_0_000_1_1  // R11 ext reset leaves Wait
    };

    logic          clk = 1'b0;
    logic          rst_n, ext_rst, sw_rst, wdog_rst, wait_stb, stop_stb, irq_any;
    logic [NP-1:0] periph_irq, stop_en_wdata, stop_en;
    logic          lvi_irq, dbg_enter, stop_en_wr, stby_req, stby_exit, pdn_req, pll_lock;
    logic          core_clk_en, periph_clk_en, sel_slow_clk, pll_pdn, osc_stby, vreg_stby, osc_pdn;
    logic [2:0]    mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.NP(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sw_rst(sw_rst), .wdog_rst(wdog_rst),
        .wait_stb(wait_stb), .stop_stb(stop_stb), .irq_any(irq_any), .periph_irq(periph_irq),
        .lvi_irq(lvi_irq), .dbg_enter(dbg_enter), .stop_en_wr(stop_en_wr),
        .stop_en_wdata(stop_en_wdata), .stby_req(stby_req), .stby_exit(stby_exit),
        .pdn_req(pdn_req), .pll_lock(pll_lock), .core_clk_en(core_clk_en),
        .periph_clk_en(periph_clk_en), .sel_slow_clk(sel_slow_clk), .pll_pdn(pll_pdn),
        .osc_stby(osc_stby), .vreg_stby(vreg_stby), .osc_pdn(osc_pdn), .stop_en(stop_en),
        .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ext_rst = 0; sw_rst = 0; wdog_rst = 0; wait_stb = 0; stop_stb = 0; irq_any = 0;
        periph_irq = '0; lvi_irq = 0; dbg_enter = 0; stop_en_wr = 0; stop_en_wdata = '0;
        stby_req = 0; stby_exit = 0; pdn_req = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Status word: {mode, core, per, vreg, osc, pll, slow, osc_pdn}
    function automatic logic [31:0] st();
        return {22'd0, mode, core_clk_en, periph_clk_en, vreg_stby, osc_stby, pll_pdn, sel_slow_clk, osc_pdn};
    endfunction

    function automatic logic [31:0] ex(input logic [2:0] m, input logic c, input logic p,
                                       input logic [3:0] th, input logic pd);
        return {22'd0, m, c, p, th, pd};
    endfunction

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        print_summary();
        $finish;
    end

    initial begin
        idle_inputs();
        pll_lock = 1'b1;
        rst_n = 1'b0;
        repeat (3) cyc();
        // R1 reset state
        chk("R1", st(), ex(3'd0, 1, 1, 4'b0000, 0));
        chk("R1", {28'd0, stop_en}, 32'h0);
        rst_n = 1'b1;
        cyc();
        chk("R1", st(), ex(3'd0, 1, 1, 4'b0000, 0));

        // R6 mask write in Run
        stop_en_wr = 1; stop_en_wdata = 4'b0101;
        cyc(); idle_inputs();
        chk("R6", {28'd0, stop_en}, 32'h5);
        // R6 write while in Wait is ignored
        wait_stb = 1; cyc(); idle_inputs();
        stop_en_wr = 1; stop_en_wdata = 4'b1111;
        cyc(); idle_inputs();
        chk("R6", {28'd0, stop_en}, 32'h5);
        irq_any = 1; cyc(); idle_inputs();
        chk("R3", {29'd0, mode}, 32'd0);

        // Table of single-cycle stimuli
        for (int i = 0; i < NV; i++) begin
            wait_stb = VEC[i][16]; stop_stb = VEC[i][15]; irq_any = VEC[i][14];
            periph_irq = VEC[i][13:10]; lvi_irq = VEC[i][9]; dbg_enter = VEC[i][8];
            ext_rst = VEC[i][7]; sw_rst = VEC[i][6]; wdog_rst = VEC[i][5];
            cyc(); idle_inputs();
            chk($sformatf("R%0d row %0d", VEC[i][20:17], i),
                {27'd0, mode, core_clk_en, periph_clk_en}, {27'd0, VEC[i][4:0]});
        end
        // R11 mask cleared by the resets in the table
        chk("R11", {28'd0, stop_en}, 32'h0);

        // R7 Standby entry walk; wait strobe mid-walk ignored
        stby_req = 1; cyc(); idle_inputs();
        chk("R7", st(), ex(3'd0, 1, 1, 4'b0001, 0));
        wait_stb = 1; cyc(); idle_inputs();
        chk("R7", st(), ex(3'd0, 1, 1, 4'b0011, 0));
        cyc();
        chk("R7", st(), ex(3'd0, 1, 1, 4'b0111, 0));
        cyc();
        chk("R7", st(), ex(3'd0, 1, 1, 4'b1111, 0));
        cyc();
        chk("R7", st(), ex(3'd3, 1, 1, 4'b1111, 0));

        // R8 exit walk with lock held low
        pll_lock = 0;
        stby_exit = 1; cyc(); idle_inputs();
        chk("R8", st(), ex(3'd3, 1, 1, 4'b0111, 0));
        cyc();
        chk("R8", st(), ex(3'd3, 1, 1, 4'b0011, 0));
        cyc();
        chk("R8", st(), ex(3'd3, 1, 1, 4'b0001, 0));
        cyc(); cyc();
        chk("R8", st(), ex(3'd3, 1, 1, 4'b0001, 0));
        pll_lock = 1;
        cyc();
        chk("R8", st(), ex(3'd3, 1, 1, 4'b0000, 0));
        cyc();
        chk("R8", st(), ex(3'd0, 1, 1, 4'b0000, 0));

        // R9 re-enter Standby, write mask there (R6), then power down
        stby_req = 1; cyc(); idle_inputs();
        repeat (4) cyc();
        chk("R7", {29'd0, mode}, 32'd3);
        stop_en_wr = 1; stop_en_wdata = 4'b0011; cyc(); idle_inputs();
        chk("R6", {28'd0, stop_en}, 32'h3);
        pdn_req = 1; cyc(); idle_inputs();
        chk("R9", st(), ex(3'd4, 0, 0, 4'b1111, 1));

        // R10 Power-Down ignores every source except the external reset
        irq_any = 1; cyc(); idle_inputs();
        chk("R10 irq", st(), ex(3'd4, 0, 0, 4'b1111, 1));
        periph_irq = 4'b1111; cyc(); idle_inputs();
        chk("R10 pirq", st(), ex(3'd4, 0, 0, 4'b1111, 1));
        lvi_irq = 1; dbg_enter = 1; cyc(); idle_inputs();
        chk("R10 lvi/dbg", st(), ex(3'd4, 0, 0, 4'b1111, 1));
        sw_rst = 1; cyc(); idle_inputs();
        chk("R10 sw", st(), ex(3'd4, 0, 0, 4'b1111, 1));
        wdog_rst = 1; cyc(); idle_inputs();
        chk("R10 wdog", st(), ex(3'd4, 0, 0, 4'b1111, 1));
        chk("R10 mask kept", {28'd0, stop_en}, 32'h3);
        ext_rst = 1; cyc(); idle_inputs();
        chk("R10 ext", st(), ex(3'd0, 1, 1, 4'b0000, 0));
        chk("R11 mask", {28'd0, stop_en}, 32'h0);

        // R1 power-on reset from Wait
        wait_stb = 1; cyc(); idle_inputs();
        rst_n = 0; cyc(); rst_n = 1;
        chk("R1", st(), ex(3'd0, 1, 1, 4'b0000, 0));

        print_summary();
        $finish;
    end

endmodule